// File: doc/BRIEF.md
# Byte-Opcode Scripted SPI Master

This block is a half-duplex SPI master that runs a short script of one-byte instructions. Software writes a 64-bit script word. The block then works through its bytes one by one, starting with bits 63:56 and moving down one byte at a time. Each instruction does one of three things: it drives a chip-select line, it shifts bytes out of a 64-bit transmit holding register, or it shifts bytes into a 64-bit receive holding register.

Data does not pass through FIFOs. Each holding register carries a full flag, which software and the sequencer use to hand over one 8-byte chunk at a time. The status word also reports overrun and underrun conditions on both registers.

The register port is a single-cycle strobe bus with a 3-bit address: 0 is clock setup, 1 is transmit data, 2 is receive data, 3 is the script and 4 is status. Read data is combinational from the address. Every transfer uses SPI mode 0 and sends the most significant bit first.

Top module: `seqspi_master`

## Requirements
- R1: After reset the status word (address 4) reads exactly bit 48 set, chip selects are all high, and SCK and MOSI are low.
- R2: A write to address 3 while idle starts the script. Instructions execute from bits 63:56 downward. The sequencer returns to idle (state field 55:48 = 0x01) on opcode 0x00, on any high nibble other than 1, 3 or 4, or after the eighth instruction.
- R3: Opcode 0x1N with N=0 drives every chip select high. With N from 1 to NUM_CS it drives only cs_n[N-1] low. At most one chip select is ever low.
- R4: Opcode 0x3N sends N bytes from the transmit register, starting with bits 63:56, MSB first. MOSI changes on falling SCK edges. When the instruction ends, transmit-full (bit 59) clears. 0x30 does nothing.
- R5: Opcode 0x4N receives N bytes, with N above 8 treated as 8, while MOSI stays low. MISO is sampled on rising SCK. The result is right-aligned in address 2, with the first byte as the most significant of the N. Receive-full (bit 63) is set.
- R6: Each SCK half period lasts DIV+1 clock cycles, where DIV is bits 63:52 of address 0. SCK rests low between bytes and while idle.
- R7: A shift-out that finds the transmit register empty waits with SCK low and sets transmit underrun (bit 57). It resumes when data is written.
- R8: A write to address 1 while transmit-full sets transmit overrun (bit 58), and the written data is discarded.
- R9: A shift-in that finishes while receive-full is set raises receive overrun (bit 62). The older data is kept.
- R10: Reading address 2 while receive-full clears that flag. Reading it while empty sets receive underrun (bit 61).
- R11: Any write to address 4 clears bits 57, 58, 61 and 62 and leaves both full flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effects on address 2) |
| addr | input | 3 | Register address |
| wdata | input | 64 | Write data |
| rdata | output | 64 | Read data, combinational from addr |
| sck | output | 1 | SPI clock |
| mosi | output | 1 | SPI data to the device |
| miso | input | 1 | SPI data from the device |
| cs_n | output | NUM_CS | Active-low chip selects |

## Verification
The table runs scripts that mix the three opcode kinds in different amounts. These include send-only, receive-only, send-then-receive, an empty 0x30, a full 8-byte receive and a capped 0x4F. Comparing the MOSI capture and the receive word across these cases catches errors in byte order, alignment and the count in the low nibble. Directed scripts check the effect of early stops, unknown opcodes and the eighth-slot limit on the final chip-select state. A 40-byte send checks the chunk handshake. Paired operations drive each flag condition: a double transmit write, a double receive, a read while empty, and a send with no data loaded.

// File: rtl/seqspi_pkg.sv
package seqspi_pkg;
    localparam logic [2:0] A_CLK  = 3'd0;
    localparam logic [2:0] A_TX   = 3'd1;
    localparam logic [2:0] A_RX   = 3'd2;
    localparam logic [2:0] A_SEQ  = 3'd3;
    localparam logic [2:0] A_STAT = 3'd4;

    typedef enum logic [7:0] {
        ST_IDLE   = 8'h01,
        ST_DECODE = 8'h02,
        ST_SOUT   = 8'h04,
        ST_SIN    = 8'h08
    } seq_st_e;

    localparam logic [3:0] OP_SEL = 4'h1;
    localparam logic [3:0] OP_OUT = 4'h3;
    localparam logic [3:0] OP_IN  = 4'h4;
endpackage

// File: rtl/seqspi_clkdiv.sv
module seqspi_clkdiv #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        tick  = 1'b0;
        if (!en) begin
            cnt_d = '0;
        end else if (cnt_q >= div) begin
            cnt_d = '0;
            tick  = 1'b1;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/seqspi_shifter.sv
module seqspi_shifter (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       tick,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic       busy,
    output logic       done,
    output logic [7:0] rx_byte
);
    typedef struct packed {
        logic       busy;
        logic       sck;
        logic       done;
        logic [2:0] bit_n;
        logic [7:0] sh;
        logic [7:0] rx;
    } sh_t;

    sh_t d, q;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (start && !q.busy) begin
            d.busy  = 1'b1;
            d.sck   = 1'b0;
            d.bit_n = '0;
            d.sh    = tx_byte;
        end else if (q.busy && tick) begin
            if (!q.sck) begin
                d.sck = 1'b1;
                d.rx  = {q.rx[6:0], miso};
            end else begin
                d.sck = 1'b0;
                if (q.bit_n == 3'd7) begin
                    d.busy = 1'b0;
                    d.done = 1'b1;
                    d.sh   = '0;
                end else begin
                    d.bit_n = q.bit_n + 3'd1;
                    d.sh    = {q.sh[6:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sck     = q.sck;
    assign mosi    = q.sh[7];
    assign busy    = q.busy;
    assign done    = q.done;
    assign rx_byte = q.rx;

    // R6: SCK moves only on a divider tick
    p_sck_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(q.sck));
    // R6: a byte always ends with SCK low
    p_done_sck_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> !q.sck);
endmodule

// File: rtl/seqspi_master.sv
module seqspi_master
    import seqspi_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int DIV_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [2:0]        addr,
    input  logic [63:0]       wdata,
    output logic [63:0]       rdata,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic [NUM_CS-1:0] cs_n
);
    localparam int SLOTS  = 8;
    localparam int SLOT_W = $clog2(SLOTS);

    typedef struct packed {
        seq_st_e           st;
        logic [63:0]       seq;
        logic [SLOT_W-1:0] slot;
        logic [3:0]        cnt;
        logic [2:0]        tx_idx;
        logic              active;
        logic [63:0]       txd;
        logic              tx_full;
        logic [63:0]       rxd;
        logic              rx_full;
        logic [63:0]       acc;
        logic              tx_ovr;
        logic              tx_unr;
        logic              rx_ovr;
        logic              rx_unr;
        logic [DIV_W-1:0]  div;
        logic [NUM_CS-1:0] cs_n;
    } st_t;

    st_t         d, q;
    logic        start, advance, tick, sh_busy, sh_done;
    logic [7:0]  tx_byte, sh_rx, op;
    logic [63:0] tx_shifted, status;

    seqspi_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .en(sh_busy), .div(q.div), .tick(tick));

    seqspi_shifter u_sh (
        .clk(clk), .rst_n(rst_n), .start(start), .tx_byte(tx_byte),
        .tick(tick), .miso(miso), .sck(sck), .mosi(mosi),
        .busy(sh_busy), .done(sh_done), .rx_byte(sh_rx));

    assign op         = q.seq[63:56];
    assign tx_shifted = q.txd << {q.tx_idx, 3'b000};

    always_comb begin
        d       = q;
        start   = 1'b0;
        advance = 1'b0;
        tx_byte = '0;

        if (wr_en) begin
            case (addr)
                A_CLK: d.div = wdata[63 -: DIV_W];
                A_TX: begin
                    if (q.tx_full) d.tx_ovr = 1'b1;
                    else begin
                        d.txd     = wdata;
                        d.tx_full = 1'b1;
                    end
                end
                A_SEQ: begin
                    if (q.st == ST_IDLE) begin
                        d.seq  = wdata;
                        d.slot = '0;
                        d.st   = ST_DECODE;
                    end
                end
                A_STAT: begin
                    d.tx_ovr = 1'b0;
                    d.tx_unr = 1'b0;
                    d.rx_ovr = 1'b0;
                    d.rx_unr = 1'b0;
                end
                default: ;
            endcase
        end
        if (rd_en && addr == A_RX) begin
            if (q.rx_full) d.rx_full = 1'b0;
            else           d.rx_unr  = 1'b1;
        end

        case (q.st)
            ST_DECODE: begin
                case (op[7:4])
                    OP_SEL: begin
                        d.cs_n = '1;
                        for (int i = 0; i < NUM_CS; i++)
                            if (op[3:0] == 4'(i + 1)) d.cs_n[i] = 1'b0;
                        advance = 1'b1;
                    end
                    OP_OUT, OP_IN: begin
                        d.cnt    = (op[3:0] > 4'd8) ? 4'd8 : op[3:0];
                        d.tx_idx = '0;
                        d.active = 1'b0;
                        d.acc    = '0;
                        if (op[3:0] == 4'd0)      advance = 1'b1;
                        else if (op[7:4] == OP_OUT) d.st  = ST_SOUT;
                        else                        d.st  = ST_SIN;
                    end
                    default: d.st = ST_IDLE;
                endcase
            end
            ST_SOUT: begin
                if (!q.active) begin
                    if (q.tx_full) begin
                        start    = 1'b1;
                        tx_byte  = tx_shifted[63:56];
                        d.active = 1'b1;
                    end else begin
                        d.tx_unr = 1'b1;
                    end
                end else if (sh_done) begin
                    d.active = 1'b0;
                    d.cnt    = q.cnt - 4'd1;
                    d.tx_idx = q.tx_idx + 3'd1;
                    if (q.cnt == 4'd1) begin
                        d.tx_full = 1'b0;
                        d.tx_idx  = '0;
                        advance   = 1'b1;
                    end
                end
            end
            ST_SIN: begin
                if (!q.active) begin
                    start    = 1'b1;
                    d.active = 1'b1;
                end else if (sh_done) begin
                    d.active = 1'b0;
                    d.acc    = {q.acc[55:0], sh_rx};
                    d.cnt    = q.cnt - 4'd1;
                    if (q.cnt == 4'd1) begin
                        if (q.rx_full) d.rx_ovr = 1'b1;
                        else begin
                            d.rxd     = {q.acc[55:0], sh_rx};
                            d.rx_full = 1'b1;
                        end
                        advance = 1'b1;
                    end
                end
            end
            default: ;
        endcase

        if (advance) begin
            d.seq  = {q.seq[55:0], 8'h00};
            d.slot = q.slot + 1'b1;
            d.st   = (q.slot == SLOT_W'(SLOTS - 1)) ? ST_IDLE : ST_DECODE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.cs_n <= '1;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        status        = '0;
        status[63]    = q.rx_full;
        status[62]    = q.rx_ovr;
        status[61]    = q.rx_unr;
        status[59]    = q.tx_full;
        status[58]    = q.tx_ovr;
        status[57]    = q.tx_unr;
        status[55:48] = q.st;
        case (addr)
            A_CLK:   rdata = {q.div, {(64 - DIV_W){1'b0}}};
            A_TX:    rdata = q.txd;
            A_RX:    rdata = q.rxd;
            A_SEQ:   rdata = q.seq;
            A_STAT:  rdata = status;
            default: rdata = '0;
        endcase
    end

    assign cs_n = q.cs_n;

    // R3: never more than one chip select low
    p_cs_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~q.cs_n) <= 1);
    // R6: SCK rests low while the sequencer is idle
    p_sck_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        q.st == ST_IDLE |-> !sck);
    // R8: write to a full transmit register is discarded and flagged
    p_tx_ovr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && addr == A_TX && q.tx_full |=> q.tx_ovr && $stable(q.txd));
    // R7: a stall on an empty transmit register raises underrun
    p_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        q.st == ST_SOUT && !q.active && !q.tx_full |=> q.tx_unr && !sck);
    // R11: status write with nothing else in flight clears every error bit
    p_stat_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && addr == A_STAT && q.st == ST_IDLE && !rd_en
        |=> !(q.tx_ovr || q.tx_unr || q.rx_ovr || q.rx_unr));
    // R5: receive-full rises only at the end of a shift-in
    p_rx_full_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.rx_full) |-> $past(q.st) == ST_SIN);
endmodule

// File: tb/sim_seqspi_master.sv
module sim_seqspi_master;
    localparam int NCS = 4;
    localparam int NV  = 6;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           wr_en = 1'b0;
    logic           rd_en = 1'b0;
    logic [2:0]     addr = 3'd0;
    logic [63:0]    wdata = '0;
    logic [63:0]    rdata;
    logic           sck, mosi, miso;
    logic [NCS-1:0] cs_n;

    int n_chk = 0;
    int n_bad = 0;

    logic [63:0] resp = '0;
    logic        slv_clr = 1'b0;
    logic [5:0]  fall_cnt;
    logic [63:0] cap;

    always #10 clk = ~clk;

    seqspi_master #(.NUM_CS(NCS), .DIV_W(12)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .sck(sck), .mosi(mosi), .miso(miso),
        .cs_n(cs_n));

    // device model: mode 0, next bit presented after each falling edge
    always @(negedge sck or posedge slv_clr)
        if (slv_clr) fall_cnt <= '0;
        else         fall_cnt <= fall_cnt + 6'd1;
    always @(posedge sck or posedge slv_clr)
        if (slv_clr) cap <= '0;
        else         cap <= {cap[62:0], mosi};
    assign miso = resp[6'd63 - fall_cnt];

    localparam logic [63:0] V_SEQ [NV] = '{64'h1131_4110_0000_0000, 64'h1232_4210_0000_0000,
        64'h1434_1000_0000_0000, 64'h1130_4310_0000_0000, 64'h1148_1000_0000_0000,
        64'h114F_1000_0000_0000};
    localparam logic [63:0] V_TX [NV] = '{64'hA500_0000_0000_0000, 64'h1234_0000_0000_0000,
        64'hDEAD_BEEF_0000_0000, 64'h0, 64'h0, 64'h0};
    localparam logic V_TXEN [NV] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0};
    localparam logic [63:0] V_RESP [NV] = '{64'h005A_0000_0000_0000, 64'h0000_BEEF_0000_0000,
        64'h0, 64'hC0FF_EE00_0000_0000, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210};
    localparam logic [63:0] V_RX [NV] = '{64'h5A, 64'hBEEF, 64'h0, 64'hC0FFEE,
        64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210};
    localparam logic V_RXF [NV] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1};
    localparam logic [63:0] V_MASK [NV] = '{64'hFFFF, 64'hFFFF_FFFF, 64'hFFFF_FFFF,
        64'hFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFF};
    localparam logic [63:0] V_CAP [NV] = '{64'hA500, 64'h1234_0000, 64'hDEAD_BEEF,
        64'h0, 64'h0, 64'h0};

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic wr(input logic [2:0] a, input logic [63:0] v);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [63:0] v);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wait_idle();
        logic [63:0] s;
        int k;
        k = 0;
        rd(3'd4, s);
        while (s[55:48] != 8'h01 && k < 20000) begin
            rd(3'd4, s);
            k++;
        end
        if (k >= 20000) check("R2 idle timeout", s[55:48], 64'h01);
    endtask

    task automatic clr_slave(input logic [63:0] r);
        resp = r;
        slv_clr = 1'b1;
        #1 slv_clr = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_up();
    end

    initial begin
        logic [63:0] s, v;
        int n;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(3'd4, s);
        check("R1 status", s, 64'h0001_0000_0000_0000);
        check("R1 cs_n", 64'(cs_n), 64'hF);
        check("R1 sck/mosi", {62'd0, sck, mosi}, 64'h0);

        wr(3'd0, {12'd1, 52'd0});

        // table walk: R4 R5 main function
        for (int i = 0; i < NV; i++) begin
            clr_slave(V_RESP[i]);
            if (V_TXEN[i]) wr(3'd1, V_TX[i]);
            wr(3'd3, V_SEQ[i]);
            wait_idle();
            check("R4 mosi bytes", cap & V_MASK[i], V_CAP[i]);
            rd(3'd4, s);
            check("R5 rx full", {63'd0, s[63]}, {63'd0, V_RXF[i]});
            check("R4 tx full cleared", {63'd0, s[59]}, 64'h0);
            check("R3 released", 64'(cs_n), 64'hF);
            if (V_RXF[i]) begin
                rd(3'd2, v);
                check("R5 rx data", v, V_RX[i]);
                rd(3'd4, s);
                check("R10 read clears full", {63'd0, s[63]}, 64'h0);
            end
        end

        // R2 stop opcode halts
        wr(3'd3, 64'h1200_1300_0000_0000);
        wait_idle();
        check("R2 stop", 64'(cs_n), 64'hD);
        // R2 eighth slot is last
        wr(3'd3, 64'h1111_1111_1111_1113);
        wait_idle();
        check("R2 eight slots R3", 64'(cs_n), 64'hB);
        // R2 unknown opcode stops
        wr(3'd3, 64'h1470_1200_0000_0000);
        wait_idle();
        check("R2 unknown op", 64'(cs_n), 64'h7);
        wr(3'd3, 64'h1000_0000_0000_0000);
        wait_idle();
        check("R3 release all", 64'(cs_n), 64'hF);

        // R6 divider: DIV=3 -> SCK high for 4 cycles
        wr(3'd0, {12'd3, 52'd0});
        clr_slave(64'h0);
        wr(3'd1, 64'h8100_0000_0000_0000);
        wr(3'd3, 64'h1131_1000_0000_0000);
        @(posedge sck);
        n = 0;
        do begin
            @(posedge clk); #1;
            n++;
        end while (sck);
        check("R6 half period", 64'(n), 64'd4);
        wait_idle();
        check("R6 byte at slow clock R4", cap & 64'hFF, 64'h81);
        wr(3'd0, {12'd1, 52'd0});

        // R7 stall on empty transmit register
        wr(3'd4, 64'h0);
        clr_slave(64'h0);
        wr(3'd3, 64'h1131_1000_0000_0000);
        repeat (40) @(negedge clk);
        rd(3'd4, s);
        check("R7 busy state", 64'(s[55:48]), 64'h04);
        check("R7 underrun", {63'd0, s[57]}, 64'h1);
        check("R7 sck idle", {63'd0, sck}, 64'h0);
        wr(3'd1, 64'h3C00_0000_0000_0000);
        wait_idle();
        check("R7 resumed", cap & 64'hFF, 64'h3C);

        // R8 transmit overrun
        wr(3'd4, 64'h0);
        wr(3'd1, 64'h6600_0000_0000_0000);
        wr(3'd1, 64'h9900_0000_0000_0000);
        rd(3'd4, s);
        check("R8 overrun", {62'd0, s[59], s[58]}, 64'h3);
        clr_slave(64'h0);
        wr(3'd3, 64'h1131_1000_0000_0000);
        wait_idle();
        check("R8 data kept", cap & 64'hFF, 64'h66);

        // R11 status write clears errors only
        wr(3'd4, 64'h0);
        rd(3'd4, s);
        check("R11 cleared", {60'd0, s[62], s[61], s[58], s[57]}, 64'h0);

        // R9 receive overrun
        clr_slave(64'h1100_0000_0000_0000);
        wr(3'd3, 64'h1141_1000_0000_0000);
        wait_idle();
        clr_slave(64'h2200_0000_0000_0000);
        wr(3'd3, 64'h1141_1000_0000_0000);
        wait_idle();
        rd(3'd4, s);
        check("R9 overrun", {62'd0, s[63], s[62]}, 64'h3);
        rd(3'd2, v);
        check("R9 old data", v, 64'h11);
        // R10 read while empty
        rd(3'd2, v);
        rd(3'd4, s);
        check("R10 underrun", {62'd0, s[63], s[61]}, 64'h1);
        // R11 full flags untouched by status write
        wr(3'd1, 64'h5500_0000_0000_0000);
        wr(3'd4, 64'h0);
        rd(3'd4, s);
        check("R11 full kept", {62'd0, s[59], s[61]}, 64'h2);
        clr_slave(64'h0);
        wr(3'd3, 64'h1131_1000_0000_0000);
        wait_idle();

        // R4 forty bytes in five chunks
        wr(3'd4, 64'h0);
        clr_slave(64'h0);
        wr(3'd1, 64'hA0A1_A2A3_A4A5_A6A7);
        wr(3'd3, 64'h1138_3838_3838_1000);
        for (int c = 1; c < 5; c++) begin
            int k;
            k = 0;
            rd(3'd4, s);
            while (s[59] && k < 20000) begin
                rd(3'd4, s);
                k++;
            end
            wr(3'd1, 64'hA0A1_A2A3_A4A5_A6A7 + 64'(c) * 64'h0808_0808_0808_0808);
        end
        wait_idle();
        check("R4 last chunk", cap, 64'hA0A1_A2A3_A4A5_A6A7 + 64'd4 * 64'h0808_0808_0808_0808);
        rd(3'd4, s);
        check("R4 forty done", {63'd0, s[59]}, 64'h0);

        finish_up();
    end
endmodule